// File: doc/BRIEF.md
# Indirectly addressed vectored interrupt controller

This block collects up to 128 interrupt sources and raises a single request line toward a processor. Each source has a trigger type, a three-bit priority, a vector word and an enable bit. None of these is mapped as a register of its own. Software first writes a source number into a select register. The per-source mode, vector and command registers then act on that one source only. The block samples the inputs and keeps a pending flag for edge requests. It chooses the highest-priority source that is both pending and enabled, and it drives `irq_out` while that source outranks the interrupt now in service.

The handler reads the interrupt vector register. That read is the acknowledge: it returns the winner's vector and pushes the winner's priority and number onto an eight-level nesting stack. It also clears the winner's edge flag. A write of any value to the end-of-interrupt register pops the stack. If nothing qualifies when the vector is read, the block returns a programmable spurious vector and leaves the stack as it was. The register port is a plain synchronous one: a write takes effect at the clock edge, and read data is registered.

Top module: `vic_top`

## Requirements
- R1: After reset the request output is low, all sources are disabled with mode 0, nothing is pending, the nesting stack is empty and the spurious vector is 0.
- R2: The select register (offset 0x00) keeps the low 7 bits of a write. The mode (0x04) and source vector (0x08) registers read and write the stored setting of the selected source only. In the mode word, priority sits in bits [2:0] and trigger type in bits [6:5], and all other mode bits read 0.
- R3: Writing the enable command (0x40) enables the selected source and writing the disable command (0x44) disables it. Bit 0 of the mask status register (0x30) reads the selected source's enable. A disabled source never raises the request, but its pending flag is kept.
- R4: Writing the set command (0x4C) makes the selected source pending and writing the clear command (0x48) removes that pending flag.
- R5: Among pending, enabled sources the highest priority wins, and ties go to the lowest source number. The winner raises `irq_out` only if its priority is strictly above the top of the nesting stack, or if the stack is empty.
- R6: Reading the interrupt vector register (0x10) while a winner qualifies returns that source's vector, pushes it onto the stack and clears its edge or software pending flag. `irq_out` is low from that clock edge on.
- R7: Any write to the end-of-interrupt register (0x38) pops one stack level, and a pop on an empty stack does nothing. Eight such writes always leave the stack empty.
- R8: Reading the interrupt vector register with no qualifying winner returns the spurious vector register (0x3C, read/write) and does not push.
- R9: The interrupt status register (0x18) reads the source number at the top of the stack, or 0 when the stack is empty.
- R10: Trigger type encoding is 00 level-low, 01 falling edge, 10 level-high, 11 rising edge. A level request follows its input, so it reappears after end-of-interrupt while the input stays active and vanishes when the input goes idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NUM_SRC | Interrupt source inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered, valid after the edge that sampled `rd_en` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
An input at the level-active value passes through one sampling register and then the request register, so `irq_out` follows it on the second clock edge. Edge detection adds one more register, which puts an edge request at the third edge. A register command takes effect at the edge that samples it, and its effect on `irq_out` shows one edge later. Read data and the drop of `irq_out` on acknowledge appear at the edge that samples the read. The bench drives on falling edges and samples on falling edges. After a stimulus it waits four edges before it looks at `irq_out`, and it reads registers only through full strobe cycles, so every check samples after its result is due.

// File: rtl/vic_pkg.sv
package vic_pkg;
   typedef enum logic [1:0] {
      TRG_LVL_LO    = 2'b00,
      TRG_EDGE_FALL = 2'b01,
      TRG_LVL_HI    = 2'b10,
      TRG_EDGE_RISE = 2'b11
   } trig_e;

   localparam logic [7:0] OFS_SEL   = 8'h00;
   localparam logic [7:0] OFS_MODE  = 8'h04;
   localparam logic [7:0] OFS_SVEC  = 8'h08;
   localparam logic [7:0] OFS_IVEC  = 8'h10;
   localparam logic [7:0] OFS_ISTAT = 8'h18;
   localparam logic [7:0] OFS_MSTAT = 8'h30;
   localparam logic [7:0] OFS_EOI   = 8'h38;
   localparam logic [7:0] OFS_SPUR  = 8'h3C;
   localparam logic [7:0] OFS_EN    = 8'h40;
   localparam logic [7:0] OFS_DIS   = 8'h44;
   localparam logic [7:0] OFS_CLR   = 8'h48;
   localparam logic [7:0] OFS_SET   = 8'h4C;

   localparam int TRIG_LSB = 5;
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank
   import vic_pkg::*;
#(
   parameter int NUM_SRC = 128,
   parameter int IDX_W   = 7,
   parameter int PRIO_W  = 3,
   parameter int VEC_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  src_i,
   input  logic [IDX_W-1:0]    sel_idx,
   input  logic                mode_we,
   input  logic [PRIO_W-1:0]   wr_prio,
   input  logic [1:0]          wr_trig,
   input  logic                vec_we,
   input  logic [VEC_W-1:0]    wr_vec,
   input  logic                en_cmd,
   input  logic                dis_cmd,
   input  logic                clr_cmd,
   input  logic                set_cmd,
   input  logic                ack,
   input  logic [IDX_W-1:0]    ack_idx,
   input  logic [IDX_W-1:0]    win_idx,
   output logic [NUM_SRC-1:0]  req_o,
   output logic [PRIO_W-1:0]   prio_o [NUM_SRC],
   output logic [PRIO_W-1:0]   sel_prio,
   output logic [1:0]          sel_trig,
   output logic [VEC_W-1:0]    sel_vec,
   output logic                sel_en,
   output logic [VEC_W-1:0]    win_vec,
   output logic                any_en
);
   logic [NUM_SRC-1:0] in_q, in_qq, en_v;
   logic [VEC_W-1:0]   vec_a  [NUM_SRC];
   logic [1:0]         trig_a [NUM_SRC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q  <= '0;
         in_qq <= '0;
      end else begin
         in_q  <= src_i;
         in_qq <= in_q;
      end
   end

   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
      logic              hit, is_ack, lvl, edg;
      logic              en_r, flag_r;
      trig_e             trig_r;
      logic [PRIO_W-1:0] prio_r;
      logic [VEC_W-1:0]  vec_r;

      assign hit    = (sel_idx == IDX_W'(gi));
      assign is_ack = ack && (ack_idx == IDX_W'(gi));

      always_comb begin
         lvl = 1'b0;
         edg = 1'b0;
         unique case (trig_r)
            TRG_LVL_LO:    lvl = !in_q[gi];
            TRG_LVL_HI:    lvl = in_q[gi];
            TRG_EDGE_FALL: edg = !in_q[gi] && in_qq[gi];
            TRG_EDGE_RISE: edg = in_q[gi] && !in_qq[gi];
            default:       lvl = 1'b0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_r   <= 1'b0;
            flag_r <= 1'b0;
            trig_r <= TRG_LVL_LO;
            prio_r <= '0;
            vec_r  <= '0;
         end else begin
            if (hit && en_cmd)       en_r <= 1'b1;
            else if (hit && dis_cmd) en_r <= 1'b0;
            if ((hit && clr_cmd) || is_ack)     flag_r <= 1'b0;
            else if ((hit && set_cmd) || edg)   flag_r <= 1'b1;
            if (hit && mode_we) begin
               trig_r <= trig_e'(wr_trig);
               prio_r <= wr_prio;
            end
            if (hit && vec_we) vec_r <= wr_vec;
         end
      end

      assign req_o[gi]  = en_r && (flag_r || lvl);
      assign prio_o[gi] = prio_r;
      assign vec_a[gi]  = vec_r;
      assign trig_a[gi] = trig_r;
      assign en_v[gi]   = en_r;
   end

   assign sel_prio = prio_o[sel_idx];
   assign sel_trig = trig_a[sel_idx];
   assign sel_vec  = vec_a[sel_idx];
   assign sel_en   = en_v[sel_idx];
   assign win_vec  = vec_a[win_idx];
   assign any_en   = |en_v;
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
   parameter int NUM_SRC = 128,
   parameter int IDX_W   = 7,
   parameter int PRIO_W  = 3
) (
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [PRIO_W-1:0]  prio_i [NUM_SRC],
   input  logic               top_valid,
   input  logic [PRIO_W-1:0]  top_prio,
   output logic               win_valid,
   output logic [IDX_W-1:0]   win_idx,
   output logic [PRIO_W-1:0]  win_prio
);
   logic found;

   always_comb begin
      found    = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_i[i] && (!found || (prio_i[i] > win_prio))) begin
            found    = 1'b1;
            win_idx  = IDX_W'(i);
            win_prio = prio_i[i];
         end
      end
      win_valid = found && (!top_valid || (win_prio > top_prio));
   end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
   parameter int DEPTH   = 8,
   parameter int ENTRY_W = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic                         pop,
   input  logic [ENTRY_W-1:0]           push_data,
   output logic [ENTRY_W-1:0]           top,
   output logic                         top_valid,
   output logic [$clog2(DEPTH+1)-1:0]   depth
);
   localparam int DW = $clog2(DEPTH + 1);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [DW-1:0]      cnt;
   logic               full;

   assign full      = (cnt == DW'(DEPTH));
   assign top_valid = (cnt != '0);
   assign top       = top_valid ? mem[AW'(cnt - 1'b1)] : '0;
   assign depth     = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (push) begin
         if (!full) begin
            mem[AW'(cnt)] <= push_data;
            cnt           <= cnt + 1'b1;
         end
      end else if (pop && top_valid) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/vic_top.sv
module vic_top
   import vic_pkg::*;
#(
   parameter int NUM_SRC = 128,
   parameter int SEL_W   = 7,
   parameter int PRIO_W  = 3,
   parameter int VEC_W   = 32,
   parameter int DATA_W  = 32,
   parameter int DEPTH   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [7:0]         addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic               irq_out
);
   localparam int IDX_W   = $clog2(NUM_SRC);
   localparam int ENTRY_W = PRIO_W + IDX_W;
   localparam int DW      = $clog2(DEPTH + 1);
   localparam logic [SEL_W:0] NSRC_L = NUM_SRC[SEL_W:0];

   if (NUM_SRC < 2 || NUM_SRC > (1 << SEL_W)) begin : g_bad_src
      $error("vic_top: NUM_SRC must lie in 2 .. 2**SEL_W");
   end
   if (PRIO_W < 1 || PRIO_W > TRIG_LSB) begin : g_bad_prio
      $error("vic_top: priority field would overlap trigger field");
   end
   if (VEC_W > DATA_W || SEL_W + 1 > DATA_W) begin : g_bad_width
      $error("vic_top: register fields wider than data bus");
   end
   if (DEPTH < (1 << PRIO_W)) begin : g_bad_depth
      $error("vic_top: stack must hold one entry per priority level");
   end

   logic [SEL_W-1:0]   sel_q;
   logic [VEC_W-1:0]   spur_q;
   logic               sel_ok;
   logic [IDX_W-1:0]   sel_idx;
   logic               ack, eoi;
   logic [NUM_SRC-1:0] req;
   logic [PRIO_W-1:0]  prio_a [NUM_SRC];
   logic [PRIO_W-1:0]  sel_prio, win_prio, top_prio;
   logic [1:0]         sel_trig;
   logic [VEC_W-1:0]   sel_vec, win_vec;
   logic               sel_en, any_en, win_valid, top_valid;
   logic [IDX_W-1:0]   win_idx, top_idx;
   logic [ENTRY_W-1:0] top_entry;
   logic [DW-1:0]      depth;
   logic [DATA_W-1:0]  mode_word, rd_next;

   wire unused_wdata = ^wdata;

   assign sel_ok   = ({1'b0, sel_q} < NSRC_L);
   assign sel_idx  = sel_q[IDX_W-1:0];
   assign ack      = rd_en && (addr == OFS_IVEC);
   assign eoi      = wr_en && (addr == OFS_EOI);
   assign top_prio = top_entry[ENTRY_W-1:IDX_W];
   assign top_idx  = top_entry[IDX_W-1:0];

   vic_src_bank #(
      .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_in),
      .sel_idx  (sel_idx),
      .mode_we  (wr_en && sel_ok && (addr == OFS_MODE)),
      .wr_prio  (wdata[PRIO_W-1:0]),
      .wr_trig  (wdata[TRIG_LSB+1:TRIG_LSB]),
      .vec_we   (wr_en && sel_ok && (addr == OFS_SVEC)),
      .wr_vec   (wdata[VEC_W-1:0]),
      .en_cmd   (wr_en && sel_ok && (addr == OFS_EN)),
      .dis_cmd  (wr_en && sel_ok && (addr == OFS_DIS)),
      .clr_cmd  (wr_en && sel_ok && (addr == OFS_CLR)),
      .set_cmd  (wr_en && sel_ok && (addr == OFS_SET)),
      .ack      (ack && win_valid),
      .ack_idx  (win_idx),
      .win_idx  (win_idx),
      .req_o    (req),
      .prio_o   (prio_a),
      .sel_prio (sel_prio),
      .sel_trig (sel_trig),
      .sel_vec  (sel_vec),
      .sel_en   (sel_en),
      .win_vec  (win_vec),
      .any_en   (any_en)
   );

   vic_arbiter #(
      .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .PRIO_W(PRIO_W)
   ) u_arb (
      .req_i     (req),
      .prio_i    (prio_a),
      .top_valid (top_valid),
      .top_prio  (top_prio),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .win_prio  (win_prio)
   );

   vic_nest_stack #(
      .DEPTH(DEPTH), .ENTRY_W(ENTRY_W)
   ) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ack && win_valid),
      .pop       (eoi),
      .push_data ({win_prio, win_idx}),
      .top       (top_entry),
      .top_valid (top_valid),
      .depth     (depth)
   );

   always_comb begin
      mode_word = '0;
      mode_word[PRIO_W-1:0] = sel_prio;
      mode_word[TRIG_LSB+1:TRIG_LSB] = sel_trig;
   end

   always_comb begin
      rd_next = '0;
      unique case (addr)
         OFS_SEL:   rd_next = DATA_W'(sel_q);
         OFS_MODE:  rd_next = sel_ok ? mode_word : '0;
         OFS_SVEC:  rd_next = sel_ok ? DATA_W'(sel_vec) : '0;
         OFS_IVEC:  rd_next = win_valid ? DATA_W'(win_vec) : DATA_W'(spur_q);
         OFS_ISTAT: rd_next = top_valid ? DATA_W'(top_idx) : '0;
         OFS_MSTAT: rd_next = DATA_W'(sel_ok && sel_en);
         OFS_SPUR:  rd_next = DATA_W'(spur_q);
         default:   rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         spur_q  <= '0;
         rdata   <= '0;
         irq_out <= 1'b0;
      end else begin
         if (wr_en && addr == OFS_SEL)  sel_q  <= wdata[SEL_W-1:0];
         if (wr_en && addr == OFS_SPUR) spur_q <= wdata[VEC_W-1:0];
         if (rd_en) rdata <= rd_next;
         irq_out <= win_valid && !ack;
      end
   end
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
   parameter int PRIO_W = 3,
   parameter int DEPTH  = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       irq_out,
   input logic                       ack,
   input logic                       eoi,
   input logic                       win_valid,
   input logic [PRIO_W-1:0]          win_prio,
   input logic                       top_valid,
   input logic [PRIO_W-1:0]          top_prio,
   input logic [$clog2(DEPTH+1)-1:0] depth,
   input logic                       any_en
);
   localparam int DW = $clog2(DEPTH + 1);

   p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= DW'(DEPTH));

   p_eoi_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !ack && depth != '0) |=> (depth == $past(depth) - 1'b1));

   p_ack_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && win_valid) |=> (depth == $past(depth) + 1'b1));

   p_ack_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && win_valid) |=> !irq_out);

   p_preempt_only_higher_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && top_valid) |-> (win_prio > top_prio));

   p_spurious_no_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !win_valid && !eoi) |=> (depth == $past(depth)));

   p_disabled_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !any_en |=> !irq_out);
endmodule

bind vic_top vic_chk #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_out   (irq_out),
   .ack       (ack),
   .eoi       (eoi),
   .win_valid (win_valid),
   .win_prio  (win_prio),
   .top_valid (top_valid),
   .top_prio  (top_prio),
   .depth     (depth),
   .any_en    (any_en)
);

// File: tb/vic_top_test.sv
module vic_top_test;
   localparam int NSRC = 128;
   localparam logic [7:0] A_SEL = 8'h00, A_MODE = 8'h04, A_SVEC = 8'h08, A_IVEC = 8'h10,
                          A_ISTAT = 8'h18, A_MSTAT = 8'h30, A_EOI = 8'h38, A_SPUR = 8'h3C,
                          A_EN = 8'h40, A_DIS = 8'h44, A_CLR = 8'h48, A_SET = 8'h4C;

   // entry: {source[6:0], prio[2:0], trig[1:0], vector[15:0]}
   localparam logic [27:0] TBL [6] = '{
      {7'd5,   3'd3, 2'b10, 16'h1505},
      {7'd17,  3'd6, 2'b11, 16'h2211},
      {7'd0,   3'd1, 2'b01, 16'h3300},
      {7'd127, 3'd7, 2'b00, 16'h447F},
      {7'd64,  3'd0, 2'b11, 16'h5540},
      {7'd33,  3'd4, 2'b10, 16'h6621}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_in = '0;
   logic            wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]      addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic            irq_out;
   int              checks = 0, fails = 0;
   logic [31:0]     v;

   always #2 clk = ~clk;

   vic_top uut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic cfg(input int idx, input logic [31:0] mode, input logic [31:0] vec);
      wr(A_SEL, idx);
      wr(A_MODE, mode);
      wr(A_SVEC, vec);
   endtask

   task automatic cmd(input int idx, input logic [7:0] a);
      wr(A_SEL, idx);
      wr(a, 32'h0);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired before the test sequence ended");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq after reset", irq_out, 0);
      rd(A_ISTAT, v); chk("R1 status empty", v, 0);
      rd(A_MSTAT, v); chk("R1 source 0 disabled", v, 0);
      rd(A_MODE, v);  chk("R1 mode zero", v, 0);
      rd(A_SPUR, v);  chk("R1 spurious zero", v, 0);
      rd(A_IVEC, v);  chk("R1 vector read gives spurious 0", v, 0);

      // R2 indirect configuration
      cfg(9, 32'h45, 32'hABCD);
      cfg(10, 32'h23, 32'h1234);
      wr(A_SEL, 9);
      rd(A_MODE, v); chk("R2 mode of source 9", v, 32'h45);
      rd(A_SVEC, v); chk("R2 vector of source 9", v, 32'hABCD);
      wr(A_SEL, 32'h18A);
      rd(A_SEL, v);  chk("R2 select keeps 7 bits", v, 32'h0A);
      rd(A_MODE, v); chk("R2 mode of source 10", v, 32'h23);
      wr(A_MODE, 32'hFFFF_FFFF);
      rd(A_MODE, v); chk("R2 only fields stored", v, 32'h67);
      wr(A_MODE, 32'h23);

      // R3 enable and disable on source 9 (level-high, prio 5)
      src_in[9] = 1'b1; settle();
      chk("R3 disabled source silent", irq_out, 0);
      cmd(9, A_EN);
      rd(A_MSTAT, v); chk("R3 mask status set", v, 1);
      settle(); chk("R3 enabled source raises", irq_out, 1);
      wr(A_DIS, 0);
      rd(A_MSTAT, v); chk("R3 mask status clear", v, 0);
      settle(); chk("R3 disable drops request", irq_out, 0);
      src_in[9] = 1'b0;

      // R4 set and clear commands on source 20 (rising, prio 2)
      cfg(20, 32'h62, 32'h2020);
      wr(A_SET, 0); settle();
      chk("R3 pending but disabled", irq_out, 0);
      wr(A_EN, 0); settle();
      chk("R4 kept pending raises on enable", irq_out, 1);
      wr(A_CLR, 0); settle();
      chk("R4 clear removes pending", irq_out, 0);
      wr(A_SET, 0); settle();
      chk("R4 set retriggers", irq_out, 1);
      rd(A_IVEC, v); chk("R4 retrigger vector", v, 32'h2020);
      wr(A_EOI, 0); settle();
      chk("R4 no repeat after end", irq_out, 0);
      wr(A_DIS, 0);

      // R5 arbitration and nesting
      cfg(40, 32'h64, 32'h40); wr(A_EN, 0);
      cfg(41, 32'h64, 32'h41); wr(A_EN, 0);
      cfg(50, 32'h66, 32'h50); wr(A_EN, 0);
      cmd(41, A_SET); cmd(40, A_SET); settle();
      chk("R5 tie raises", irq_out, 1);
      rd(A_IVEC, v); chk("R5 tie goes to lower index", v, 32'h40);
      settle(); chk("R5 equal priority does not preempt", irq_out, 0);
      cmd(50, A_SET); settle();
      chk("R5 higher priority preempts", irq_out, 1);
      rd(A_IVEC, v); chk("R6 nested vector", v, 32'h50);
      rd(A_ISTAT, v); chk("R9 status nested top", v, 50);
      wr(A_EOI, 0); settle();
      rd(A_ISTAT, v); chk("R7 pop returns to outer", v, 40);
      chk("R5 still blocked by outer", irq_out, 0);
      wr(A_EOI, 0); settle();
      chk("R5 waiting source raises after pop", irq_out, 1);
      rd(A_IVEC, v); chk("R5 second tie source", v, 32'h41);
      wr(A_EOI, 0);
      cmd(40, A_DIS); cmd(41, A_DIS); cmd(50, A_DIS);

      // R8 spurious vector
      wr(A_SPUR, 32'hDEAD_BEEF);
      rd(A_SPUR, v); chk("R8 spurious readback", v, 32'hDEAD_BEEF);
      rd(A_IVEC, v); chk("R8 idle vector is spurious", v, 32'hDEAD_BEEF);
      rd(A_ISTAT, v); chk("R8 no push on spurious", v, 0);

      // R7 eight end writes return to idle
      cfg(60, 32'h61, 32'h60); wr(A_EN, 0);
      cfg(61, 32'h63, 32'h61); wr(A_EN, 0);
      cfg(62, 32'h65, 32'h62); wr(A_EN, 0);
      cmd(60, A_SET); settle(); rd(A_IVEC, v);
      cmd(61, A_SET); settle(); rd(A_IVEC, v);
      cmd(62, A_SET); settle(); rd(A_IVEC, v);
      chk("R6 third nested vector", v, 32'h62);
      rd(A_ISTAT, v); chk("R9 status deep", v, 62);
      for (int k = 0; k < 8; k++) wr(A_EOI, 0);
      settle();
      rd(A_ISTAT, v); chk("R7 idle after eight ends", v, 0);
      chk("R7 no request when idle", irq_out, 0);
      rd(A_IVEC, v); chk("R7 idle vector spurious", v, 32'hDEAD_BEEF);
      cmd(60, A_DIS); cmd(61, A_DIS); cmd(62, A_DIS);

      // table walk over trigger types (R10, R6, R9)
      for (int k = 0; k < 6; k++) begin
         logic [6:0]  idx;
         logic [2:0]  pr;
         logic [1:0]  tg;
         logic [15:0] vc;
         logic        idle, lvl;
         {idx, pr, tg, vc} = TBL[k];
         idle = (tg == 2'b00) || (tg == 2'b01);
         lvl  = !tg[0];
         src_in[idx] = idle; settle();
         cfg(idx, {25'd0, tg, 2'b00, pr}, {16'd0, vc});
         wr(A_EN, 0); settle();
         chk($sformatf("R10 idle input quiet src %0d", idx), irq_out, 0);
         src_in[idx] = !idle; settle();
         chk($sformatf("R10 active input raises src %0d", idx), irq_out, 1);
         rd(A_IVEC, v);
         chk($sformatf("R6 vector src %0d", idx), v, {16'd0, vc});
         chk($sformatf("R6 request drops src %0d", idx), irq_out, 0);
         rd(A_ISTAT, v);
         chk($sformatf("R9 status src %0d", idx), v, {25'd0, idx});
         wr(A_EOI, 0); settle();
         chk($sformatf("R10 after end src %0d", idx), irq_out, lvl);
         src_in[idx] = idle; settle();
         chk($sformatf("R10 idle again src %0d", idx), irq_out, 0);
         if (lvl) begin
            rd(A_IVEC, v); rd(A_ISTAT, v);
         end
         wr(A_EOI, 0);
         cmd(idx, A_DIS);
      end

      finish_run();
   end
endmodule